// File: doc/BRIEF.md
# Multichannel PWM Bank with Channel Enables and Shutdown Gating

This block turns a bank of 18 duty bytes into 18 pulse-width-modulated on/off drive signals for LED current sinks. One shared 8-bit ramp counter serves every channel. Each channel compares that ramp against its own active duty value. A channel output is high while the ramp is below the duty value, so each channel has 256 brightness steps.

Every output passes through three gates: its own enable bit, a software run bit and an active-low shutdown pin. The shutdown pin is asynchronous to the block, so it goes through a synchronizer first. A clock-enable input sets how fast the ramp advances. New duty bytes are taken into the active copy only at the ramp wrap, so a period never holds a pulse of mixed length. Shutdown only gates the outputs. The ramp, the active duty copies and every upstream register keep running or keep their contents. When shutdown ends, the outputs come back in the phase they would have had anyway.

Top module: `led_pwm_bank`

## Requirements
- R1: The shared ramp counter advances by one on each clock where `tick_en` is 1 and holds otherwise. It wraps from 255 to 0. While `tick_en` is 0 and no other input changes, every output holds its value.
- R2: With the channel enabled, `soft_run_i`=1 and the pin high, channel i (duty byte at `duty_i[8*i+7:8*i]`) drives high exactly while the ramp value is less than its active duty. Over one ramp period, duty 0 gives 0 high ticks, duty 128 gives 128 and duty 255 gives 255 of 256.
- R3: A channel's active duty is loaded from `duty_i` only on a clock where `tick_en` is 1 and the ramp is at 255. A duty change made at any other point in the period does not change the current period's output.
- R4: When bit i of `chan_en_i` is 0, `drive_o[i]` is 0 in the same cycle, whatever the duty value.
- R5: When `soft_run_i` is 0, all outputs are 0 in the same cycle. When it is 1, the outputs run normally.
- R6: `hw_sd_n_i` passes through two flops. The outputs are forced to 0 from the second rising edge after the pin goes low. They are released from the second rising edge after the pin goes high.
- R7: Shutdown from either source changes neither the ramp nor the active duties. After release, the outputs match the undisturbed schedule.
- R8: During and right after synchronous reset (`rst_n`=0), all outputs are 0. The ramp is at 0, the active duties are 0 and the synchronizer reads as shut down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Ramp advance enable, sets the PWM rate |
| duty_i | input | 144 | 18 duty bytes, channel i at bits [8*i+7:8*i] |
| chan_en_i | input | 18 | Per-channel enable, bit i for channel i, 1 = on |
| soft_run_i | input | 1 | Software run bit, 0 forces all outputs off |
| hw_sd_n_i | input | 1 | Asynchronous shutdown pin, low forces all outputs off |
| drive_o | output | 18 | Per-channel drive enable, 1 = sink on |

## Verification
The bench counts high ticks over a full ramp period for duties 0, 128 and 255. A design with an off-by-one comparison would give 1 or 256 high ticks at the ends of the range. It changes a duty in the middle of a period and checks that the old value still governs. A design without the wrap-time load would cut the pulse short and produce a runt.

It pulses the shutdown pin and the run bit, then checks the two-edge latency of the pin. After release it checks that the phase resumes on schedule. A design that reset the ramp or cleared the duties on shutdown would come back out of phase or dark. Random stretches with gaps in `tick_en` and enable toggles are compared cycle by cycle against a bench model of the ramp.

// File: rtl/led_pwm_pkg.sv
// Package: shared defaults and helpers for the PWM bank.
// Assumes duty and ramp share one width; the ramp period is 2**DUTY_W ticks.
package led_pwm_pkg;
    localparam int CH_N_DEF       = 18;
    localparam int DUTY_W_DEF     = 8;
    localparam int SYNC_DEPTH_DEF = 2;

    // Why a channel output is currently off (used for readability in gating).
    typedef enum logic [1:0] {
        GATE_OPEN    = 2'd0,
        GATE_CHAN    = 2'd1,
        GATE_SOFT    = 2'd2,
        GATE_PIN     = 2'd3
    } gate_reason_e;

    // Classify the gating state of one channel, highest-level cause first.
    function automatic gate_reason_e gate_reason(input logic pin_run,
                                                 input logic soft_run,
                                                 input logic chan_en);
        if (!pin_run)       return GATE_PIN;
        else if (!soft_run) return GATE_SOFT;
        else if (!chan_en)  return GATE_CHAN;
        else                return GATE_OPEN;
    endfunction
endpackage

// File: rtl/pwm_ramp_counter.sv
// Shared ramp counter: advances on tick_en, wraps at its maximum and flags
// the wrap clock so channels can load new duty values.
// Assumes a synchronous active-low reset; the ramp restarts at 0.
module pwm_ramp_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] cnt_q;

    // Wrap strobe: the tick that takes the ramp from maximum back to zero.
    always_comb begin
        wrap_o = tick_en && (cnt_q == CNT_MAX);
    end

    // Ramp register: step on tick, natural modulo wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/sd_pin_sync.sv
// Synchronizer for the asynchronous active-low shutdown pin.
// Resets to the "shut down" value so outputs stay off right after reset.
// Assumes STAGES >= 2.
module sd_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n_i,
    output logic run_o
);
    logic [STAGES-1:0] sync_q;

    // Flop chain: sample the pin into the first stage, shift toward the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_n_i};
        end
    end

    assign run_o = sync_q[STAGES-1];
endmodule

// File: rtl/pwm_channel_slice.sv
// One PWM channel: holds the active duty copy, loaded only at the ramp
// wrap, and compares it against the shared ramp. The output is gated by the
// channel enable and the combined run condition.
// Assumes cnt_i and load_i come from the shared ramp counter.
module pwm_channel_slice #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] duty_i,
    input  logic [W-1:0] cnt_i,
    input  logic         en_i,
    input  logic         pin_run_i,
    input  logic         soft_run_i,
    output logic [W-1:0] duty_act_o,
    output logic         drive_o
);
    import led_pwm_pkg::*;

    logic [W-1:0]  duty_act_q;
    logic          cmp_hi;
    gate_reason_e  reason;

    // Active duty copy: take the pending byte only on the wrap tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_act_q <= '0;
        end else if (load_i) begin
            duty_act_q <= duty_i;
        end
    end

    // Compare stage: high while the ramp sits below the active duty.
    always_comb begin
        cmp_hi = (cnt_i < duty_act_q);
    end

    // Output gate: only an open gate lets the compare result through.
    always_comb begin
        reason  = gate_reason(pin_run_i, soft_run_i, en_i);
        drive_o = (reason == GATE_OPEN) && cmp_hi;
    end

    assign duty_act_o = duty_act_q;
endmodule

// File: rtl/led_pwm_bank.sv
// Top of the multichannel PWM bank: one shared ramp, one shutdown pin
// synchronizer and CH_N channel slices built by generate.
// Assumes duty_i is packed with channel i at bits [DUTY_W*i +: DUTY_W].
module led_pwm_bank #(
    parameter int CH_N       = led_pwm_pkg::CH_N_DEF,
    parameter int DUTY_W     = led_pwm_pkg::DUTY_W_DEF,
    parameter int SYNC_DEPTH = led_pwm_pkg::SYNC_DEPTH_DEF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick_en,
    input  logic [CH_N*DUTY_W-1:0] duty_i,
    input  logic [CH_N-1:0]        chan_en_i,
    input  logic                   soft_run_i,
    input  logic                   hw_sd_n_i,
    output logic [CH_N-1:0]        drive_o
);
    localparam int BUS_W = CH_N * DUTY_W;

    logic [DUTY_W-1:0] ramp;
    logic              wrap;
    logic              pin_run;
    logic [BUS_W-1:0]  duty_act;

    pwm_ramp_counter #(
        .W (DUTY_W)
    ) i_ramp (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .cnt_o   (ramp),
        .wrap_o  (wrap)
    );

    sd_pin_sync #(
        .STAGES (SYNC_DEPTH)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n_i (hw_sd_n_i),
        .run_o   (pin_run)
    );

    for (genvar g = 0; g < CH_N; g++) begin : g_ch
        pwm_channel_slice #(
            .W (DUTY_W)
        ) i_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (wrap),
            .duty_i     (duty_i[g*DUTY_W +: DUTY_W]),
            .cnt_i      (ramp),
            .en_i       (chan_en_i[g]),
            .pin_run_i  (pin_run),
            .soft_run_i (soft_run_i),
            .duty_act_o (duty_act[g*DUTY_W +: DUTY_W]),
            .drive_o    (drive_o[g])
        );
    end
endmodule

// File: rtl/led_pwm_bank_chk.sv
// Checker for led_pwm_bank, attached by bind. Watches the ports plus the
// ramp and the collected active duties.
module led_pwm_bank_chk #(
    parameter int CH_N   = 18,
    parameter int DUTY_W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   tick_en,
    input logic [CH_N*DUTY_W-1:0] duty_i,
    input logic [CH_N-1:0]        chan_en_i,
    input logic                   soft_run_i,
    input logic                   hw_sd_n_i,
    input logic [CH_N-1:0]        drive_o,
    input logic [DUTY_W-1:0]      ramp,
    input logic [CH_N*DUTY_W-1:0] duty_act
);
    localparam logic [DUTY_W-1:0] RMAX = {DUTY_W{1'b1}};

    // R1: ramp holds without a tick
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(ramp));
    // R1: ramp wraps to zero after its maximum
    a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && ramp == RMAX) |=> ramp == '0);
    // R3: active duties only change on the wrap tick
    a_r3_no_midload: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_en && ramp == RMAX) |=> $stable(duty_act));
    // R3: the wrap tick captures the pending bytes
    a_r3_wrap_load: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && ramp == RMAX) |=> duty_act == $past(duty_i));
    // R4: disabled channels never drive
    a_r4_chan_off: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_o & ~chan_en_i) == '0);
    // R5: software shutdown silences every output
    a_r5_soft_off: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_run_i |-> drive_o == '0);
    // R6: pin low for two edges silences every output
    a_r6_pin_off: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!hw_sd_n_i) && $past(!hw_sd_n_i, 2)) |-> drive_o == '0);
    // R8: the cycle after a reset clock has all outputs low
    a_r8_reset_dark: assert property (@(posedge clk)
        !rst_n |=> drive_o == '0);

    for (genvar g = 0; g < CH_N; g++) begin : g_cmp
        // R2: a driving channel sits below its active duty
        a_r2_below_duty: assert property (@(posedge clk) disable iff (!rst_n)
            drive_o[g] |-> (ramp < duty_act[g*DUTY_W +: DUTY_W]));
    end
endmodule

bind led_pwm_bank led_pwm_bank_chk #(
    .CH_N   (CH_N),
    .DUTY_W (DUTY_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .duty_i     (duty_i),
    .chan_en_i  (chan_en_i),
    .soft_run_i (soft_run_i),
    .hw_sd_n_i  (hw_sd_n_i),
    .drive_o    (drive_o),
    .ramp       (ramp),
    .duty_act   (duty_act)
);

// File: tb/test_led_pwm_bank.sv
`timescale 1ns/100ps
module test_led_pwm_bank;
    localparam int NCH = 18;
    localparam int DW  = 8;
    localparam int WATCHDOG = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick_en = 1'b0;
    logic [NCH*DW-1:0] duty_i = '0;
    logic [NCH-1:0]    chan_en_i = '0;
    logic              soft_run_i = 1'b0;
    logic              hw_sd_n_i = 1'b0;
    logic [NCH-1:0]    drive_o;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    // bench model state, from the requirements
    int        m_cnt = 0;
    logic [7:0] m_duty [NCH];
    logic      m_s1 = 0, m_s2 = 0;

    led_pwm_bank i_led_pwm_bank (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .duty_i(duty_i),
        .chan_en_i(chan_en_i), .soft_run_i(soft_run_i),
        .hw_sd_n_i(hw_sd_n_i), .drive_o(drive_o)
    );

    always #2.5 clk = ~clk;

    function automatic logic [NCH-1:0] exp_drive();
        logic [NCH-1:0] e;
        for (int i = 0; i < NCH; i++)
            e[i] = m_s2 && soft_run_i && chan_en_i[i] && (m_cnt < int'(m_duty[i]));
        return e;
    endfunction

    function automatic string pick_tag();
        if (!m_s2) return "R6";
        if (!soft_run_i) return "R5";
        if (chan_en_i != '1) return "R4";
        return "R2";
    endfunction

    // one clock: update model with inputs present at the edge, sample at negedge
    task automatic step();
        @(posedge clk);
        cyc++;
        if (!rst_n) begin
            m_cnt = 0; m_s1 = 0; m_s2 = 0;
            for (int i = 0; i < NCH; i++) m_duty[i] = 8'd0;
        end else begin
            if (tick_en && m_cnt == 255) begin
                for (int i = 0; i < NCH; i++) m_duty[i] = duty_i[i*DW +: DW];
                m_cnt = 0;
            end else if (tick_en) begin
                m_cnt++;
            end
            m_s2 = m_s1;
            m_s1 = hw_sd_n_i;
        end
        @(negedge clk);
    endtask

    task automatic check_vec(input string tag);
        logic [NCH-1:0] e;
        e = exp_drive();
        n_vec++;
        if (drive_o !== e) begin
            n_bad++;
            $display("FAIL %s cycle %0d: drive_o=%h expected %h", tag, cyc, drive_o, e);
        end
    endtask

    task automatic check_bit(input string tag, input int actual, input int expected);
        n_vec++;
        if (actual != expected) begin
            n_bad++;
            $display("FAIL %s cycle %0d: got %0d expected %0d", tag, cyc, actual, expected);
        end
    endtask

    task automatic set_duty(input int ch, input int v);
        duty_i[ch*DW +: DW] = v[7:0];
    endtask

    task automatic wait_wrap_load();
        while (m_cnt != 255) step();
        step();
    endtask

    initial begin
        while (cyc < WATCHDOG && !done) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog: cycles=%0d expected below %0d", cyc, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [NCH-1:0] held;
        int hi0, hi1, hi2;
        void'($urandom(32'd20240611));
        // R8: reset state with everything requested on
        duty_i = {NCH*DW{1'b1}}; chan_en_i = '1; soft_run_i = 1; hw_sd_n_i = 1; tick_en = 1;
        repeat (4) step();
        check_vec("R8");
        check_bit("R8", int'(drive_o), 0);
        rst_n = 1;
        step(); check_vec("R8");
        repeat (3) step(); check_vec("R6");

        // R2: high-tick counts over one period for 255, 0, 128
        set_duty(0, 255); set_duty(1, 0); set_duty(2, 128);
        wait_wrap_load();
        hi0 = 0; hi1 = 0; hi2 = 0;
        for (int k = 0; k < 256; k++) begin
            check_vec("R2");
            hi0 += drive_o[0]; hi1 += drive_o[1]; hi2 += drive_o[2];
            if (k != 255) step();
        end
        check_bit("R2 duty255", hi0, 255);
        check_bit("R2 duty0", hi1, 0);
        check_bit("R2 duty128", hi2, 128);

        // R3: mid-period change keeps old duty until the wrap
        set_duty(3, 200);
        wait_wrap_load();
        while (m_cnt != 100) step();
        set_duty(3, 10);
        step();
        check_bit("R3 old duty kept", int'(drive_o[3]), 1);
        check_vec("R3");
        wait_wrap_load();
        while (m_cnt != 20) step();
        check_bit("R3 new duty at wrap", int'(drive_o[3]), 0);

        // R1: no ticks, outputs hold
        set_duty(4, 60);
        wait_wrap_load();
        while (m_cnt != 30) step();
        tick_en = 0;
        step(); held = drive_o;
        repeat (20) begin
            step();
            check_vec("R1");
        end
        check_bit("R1 hold", int'(drive_o == held), 1);
        tick_en = 1;

        // R4: clearing an enable forces that channel off at once
        while (m_cnt != 10) step();
        chan_en_i[0] = 0;
        #0.5;
        check_bit("R4 disabled ch0", int'(drive_o[0]), 0);
        step(); check_vec("R4");
        chan_en_i[0] = 1;

        // R5: software shutdown, then resume in phase (R7)
        soft_run_i = 0;
        #0.5;
        check_bit("R5 soft off", int'(drive_o), 0);
        repeat (300) begin step(); check_vec("R5"); end
        soft_run_i = 1;
        step(); check_vec("R7");

        // R6: pin latency of two edges, then R7 resume
        while (m_cnt != 5) step();
        hw_sd_n_i = 0;
        step(); check_bit("R6 one edge still on", int'(drive_o[0]), 1);
        step(); check_bit("R6 two edges off", int'(drive_o), 0);
        repeat (400) begin step(); check_vec("R6"); end
        hw_sd_n_i = 1;
        step(); check_bit("R6 one edge still off", int'(drive_o), 0);
        step(); check_vec("R7");
        check_bit("R7 ch0 duty255 resumes", int'(drive_o[0]), int'(m_cnt < 255));

        // random mix against the model
        for (int c = 0; c < 20000; c++) begin
            tick_en = ($urandom % 4) != 0;
            if ($urandom % 64 == 0) set_duty($urandom % NCH, $urandom % 256);
            if ($urandom % 200 == 0) chan_en_i[$urandom % NCH] ^= 1'b1;
            if ($urandom % 700 == 0) soft_run_i = ~soft_run_i;
            if ($urandom % 900 == 0) hw_sd_n_i = ~hw_sd_n_i;
            step();
            check_vec(pick_tag());
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule